// File: doc/BRIEF.md
# Dual-View Interrupt Status Register

This block gathers up to 32 event flags for a network controller and raises a single interrupt line. Each flag is set by a one-cycle pulse on its event input. The pulse may come from an on-chip condition, or from an entry that has been placed in a transmit or receive status queue. Once set, a flag stays set until software clears it. Masks have no effect on the flags, so software can poll events that are masked.

Software can reach the same flags at two register addresses. The keep view can be read any number of times without side effects. Software clears individual flags there by writing ones to their positions. The acknowledge view returns the flags and clears all of them in the same access. A handler can therefore either clear flags one by one or take every pending event with a single read.

A per-flag enable mask and a global enable bit both gate the interrupt line. The line is driven from a register.

Top module: `irq_status_unit`

## Requirements
- R1: After reset, all status flags, the enable mask and the global enable bit read as zero, and `irq_o` is low.
- R2: A read at word address 0 (keep view) returns the status flags in the same cycle and leaves every flag unchanged.
- R3: A write at address 0 clears each flag whose `bus_wdata` bit is 1 and leaves each flag whose bit is 0 unchanged.
- R4: A read at address 1 (acknowledge view) returns the status flags in the same cycle and clears all of them at the clock edge that ends the access.
- R5: A one-cycle pulse on `evt_in[i]` sets flag i at the next edge, and the flag holds until it is cleared. When a pulse coincides with a clear of the same flag, the flag ends up set.
- R6: Address 2 holds the per-flag enable mask and reads back what was written. Address 3 holds the global enable in bit 0, and its other bits read as zero.
- R7: `irq_o` is high in the cycle after the global enable is 1 and at least one flag is set with its enable bit 1. In all other cases it is low in the cycle after.
- R8: A flag is set and held whatever the state of its enable bit and of the global enable.
- R9: A write at address 1 has no effect. Addresses 4 and above read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Word address of the register access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the address |
| evt_in | input | N_EVT | Event pulses, one bit per status flag |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions assume that the event inputs and bus strobes are clean, known values at every clock edge after reset, and that each read or write lasts exactly one cycle. Reads and writes may occur together in any combination. The bench drives all inputs half a cycle away from the sampling edge and keeps every value known. It also produces same-cycle collisions on purpose: event pulses during keep-view clears, event pulses during acknowledge reads, and a read and a write in the same cycle. These collisions exercise the rule that a set beats a clear.

// File: rtl/irq_status_pkg.sv
`timescale 1ns/1ps
package irq_status_pkg;
   // Register word offsets; decode compares the full address.
   typedef enum logic [1:0] {
      REG_KEEP = 2'd0,   // preserving view, write ones to clear
      REG_ACK  = 2'd1,   // clear-all-on-read view
      REG_ENA  = 2'd2,   // per-flag enable mask
      REG_GLB  = 2'd3    // global enable in bit 0
   } reg_sel_e;

   localparam int unsigned GLB_BIT = 0;
endpackage

// File: rtl/irq_status_bank.sv
`timescale 1ns/1ps
module irq_status_bank #(
   parameter int unsigned N_EVT = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EVT-1:0] evt_i,
   input  logic [N_EVT-1:0] w1c_i,
   input  logic             clr_all_i,
   output logic [N_EVT-1:0] status_o
);
   logic [N_EVT-1:0] st_q;

   generate
      for (genvar i = 0; i < N_EVT; i++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               st_q[i] <= 1'b0;
            else
               st_q[i] <= evt_i[i] | (st_q[i] & ~w1c_i[i] & ~clr_all_i);
         end
      end
   endgenerate

   assign status_o = st_q;

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status_o & $past(evt_i)) == $past(evt_i)));                    // R5
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_all_i |=> (status_o == $past(evt_i)));                                 // R4
   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status_o & $past(w1c_i & ~evt_i)) == '0));                      // R3
   AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status_o & ~$past(status_o | evt_i)) == '0));                   // R5
endmodule

// File: rtl/irq_mask_regs.sv
`timescale 1ns/1ps
module irq_mask_regs #(
   parameter int unsigned N_EVT = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en_i,
   input  logic             wr_glb_i,
   input  logic [N_EVT-1:0] en_data_i,
   input  logic             glb_data_i,
   output logic [N_EVT-1:0] en_o,
   output logic             glb_o
);
   logic [N_EVT-1:0] en_q;
   logic             glb_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         glb_q <= 1'b0;
      end else begin
         if (wr_en_i)  en_q  <= en_data_i;
         if (wr_glb_i) glb_q <= glb_data_i;
      end
   end

   assign en_o  = en_q;
   assign glb_o = glb_q;

   AST_ENA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i |=> $stable(en_o));                                               // R6
   AST_GLB_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_glb_i |=> $stable(glb_o));                                             // R6
endmodule

// File: rtl/irq_line_gen.sv
`timescale 1ns/1ps
module irq_line_gen #(
   parameter int unsigned N_EVT   = 32,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EVT-1:0] status_i,
   input  logic [N_EVT-1:0] en_i,
   input  logic             glb_i,
   output logic             irq_o
);
   logic pend;
   assign pend = glb_i & (|(status_i & en_i));

   generate
      if (OUT_REG) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= pend;
         end
         assign irq_o = irq_q;

         AST_GLB_GATES: assert property (@(posedge clk) disable iff (!rst_n)
            !glb_i |=> !irq_o);                                                  // R7
      end else begin : g_comb
         assign irq_o = pend;
      end
   endgenerate
endmodule

// File: rtl/irq_status_unit.sv
`timescale 1ns/1ps
module irq_status_unit
   import irq_status_pkg::*;
#(
   parameter int unsigned N_EVT   = 32,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 4,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [N_EVT-1:0]  evt_in,
   output logic              irq_o
);
   localparam int unsigned PAD_W = (DATA_W > N_EVT) ? DATA_W - N_EVT : 1;

   generate
      if (DATA_W < N_EVT) begin : g_bad_width
         $error("DATA_W must be at least N_EVT");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W must be at least 2");
      end
      if (N_EVT < 1) begin : g_bad_evt
         $error("N_EVT must be at least 1");
      end
   endgenerate

   // Address decode on the full word address.
   logic sel_keep, sel_ack, sel_ena, sel_glb;
   assign sel_keep = (bus_addr == ADDR_W'(REG_KEEP));
   assign sel_ack  = (bus_addr == ADDR_W'(REG_ACK));
   assign sel_ena  = (bus_addr == ADDR_W'(REG_ENA));
   assign sel_glb  = (bus_addr == ADDR_W'(REG_GLB));

   logic [N_EVT-1:0] status, en_mask, w1c;
   logic             glb_en, clr_all;

   assign w1c     = (bus_wr && sel_keep) ? bus_wdata[N_EVT-1:0] : '0;
   assign clr_all = bus_rd && sel_ack;

   irq_status_bank #(.N_EVT(N_EVT)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_i     (evt_in),
      .w1c_i     (w1c),
      .clr_all_i (clr_all),
      .status_o  (status)
   );

   irq_mask_regs #(.N_EVT(N_EVT)) u_masks (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en_i    (bus_wr && sel_ena),
      .wr_glb_i   (bus_wr && sel_glb),
      .en_data_i  (bus_wdata[N_EVT-1:0]),
      .glb_data_i (bus_wdata[GLB_BIT]),
      .en_o       (en_mask),
      .glb_o      (glb_en)
   );

   irq_line_gen #(.N_EVT(N_EVT), .OUT_REG(OUT_REG)) u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .status_i (status),
      .en_i     (en_mask),
      .glb_i    (glb_en),
      .irq_o    (irq_o)
   );

   // Widen flag vectors to the bus width.
   logic [DATA_W-1:0] st_word, en_word, glb_word;
   generate
      if (DATA_W > N_EVT) begin : g_pad
         assign st_word = {{PAD_W{1'b0}}, status};
         assign en_word = {{PAD_W{1'b0}}, en_mask};
      end else begin : g_nopad
         assign st_word = status;
         assign en_word = en_mask;
      end
   endgenerate

   always_comb begin
      glb_word          = '0;
      glb_word[GLB_BIT] = glb_en;
   end

   always_comb begin
      bus_rdata = '0;
      if (sel_keep || sel_ack) bus_rdata = st_word;
      else if (sel_ena)        bus_rdata = en_word;
      else if (sel_glb)        bus_rdata = glb_word;
   end

   AST_KEEP_READ_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && sel_keep && !bus_wr) |=> ((status & $past(status)) == $past(status)));   // R2
   generate
      if (OUT_REG) begin : g_irq_chk
         AST_IRQ_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
            ((status & en_mask) == '0) |=> !irq_o);                                      // R7
      end
   endgenerate
endmodule

// File: tb/sim_irq_status_unit.sv
`timescale 1ns/1ps
module sim_irq_status_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] evt_in = '0;
   logic        irq_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // Reference state
   logic [31:0] m_st = '0, m_en = '0;
   logic        m_glb = 1'b0, m_irq = 1'b0;

   always #10 clk = ~clk;

   irq_status_unit u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .evt_in(evt_in), .irq_o(irq_o)
   );

   function automatic logic [31:0] exp_read(input logic [3:0] a);
      case (a)
         4'd0, 4'd1: return m_st;
         4'd2:       return m_en;
         4'd3:       return {31'b0, m_glb};
         default:    return 32'h0;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // One bus cycle; irq compared every clock, read data on reads.
   task automatic cyc(input string tag, input logic [3:0] a, input logic rd,
                      input logic wr, input logic [31:0] wd, input logic [31:0] ev);
      logic [31:0] clr, nst, nen;
      logic        nglb, nirq;
      @(negedge clk);
      bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = wd; evt_in = ev;
      #2;
      chk("R7 irq", {31'b0, irq_o}, {31'b0, m_irq});
      if (rd) chk(tag, bus_rdata, exp_read(a));
      clr  = ((wr && a == 4'd0) ? wd : 32'h0) | ((rd && a == 4'd1) ? 32'hFFFF_FFFF : 32'h0);
      nst  = ev | (m_st & ~clr);
      nen  = (wr && a == 4'd2) ? wd : m_en;
      nglb = (wr && a == 4'd3) ? wd[0] : m_glb;
      nirq = m_glb && ((m_st & m_en) != 0);
      @(posedge clk);
      #1;
      m_st = nst; m_en = nen; m_glb = nglb; m_irq = nirq;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) cyc("idle", 4'd0, 1'b0, 1'b0, 32'h0, 32'h0);
   endtask

   initial begin
      #5_000_000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      chk("R1 irq", {31'b0, irq_o}, 32'h0);
      cyc("R1 status", 4'd0, 1, 0, 0, 0);
      cyc("R1 enable", 4'd2, 1, 0, 0, 0);
      cyc("R1 global", 4'd3, 1, 0, 0, 0);

      // R5 set and hold, R2 preserving reads
      cyc("R5 set", 4'd0, 0, 0, 0, 32'h0000_0005);
      idle(2);
      cyc("R2 keep read a", 4'd0, 1, 0, 0, 0);
      cyc("R2 keep read b", 4'd0, 1, 0, 0, 0);
      chk("R5 hold", m_st, 32'h5);

      // R3 write ones to clear
      cyc("R3 w1c", 4'd0, 0, 1, 32'h0000_0001, 0);
      cyc("R3 after w1c", 4'd0, 1, 0, 0, 0);
      chk("R3 model", m_st, 32'h4);

      // R5 set wins over clear
      cyc("R5 collide", 4'd0, 0, 1, 32'h0000_0004, 32'h0000_0004);
      cyc("R5 survived", 4'd0, 1, 0, 0, 0);

      // R8 masked event still visible
      cyc("R8 evt", 4'd0, 0, 0, 0, 32'h8000_0000);
      cyc("R8 visible", 4'd1 - 4'd1, 1, 0, 0, 0);
      idle(2);

      // R6 masks
      cyc("R6 wr ena", 4'd2, 0, 1, 32'h0000_0004, 0);
      cyc("R6 rd ena", 4'd2, 1, 0, 0, 0);
      cyc("R6 wr glb", 4'd3, 0, 1, 32'hFFFF_FFFF, 0);
      cyc("R6 rd glb", 4'd3, 1, 0, 0, 0);
      idle(3);
      chk("R7 asserted", {31'b0, irq_o}, 32'h1);

      // R4 clear-on-read
      cyc("R4 ack read", 4'd1, 1, 0, 0, 0);
      cyc("R4 cleared", 4'd0, 1, 0, 0, 0);
      idle(2);
      cyc("R4 ack with evt", 4'd1, 0, 0, 0, 32'h0000_0002);
      cyc("R4 ack with evt", 4'd1, 1, 0, 0, 32'h0000_0002);
      cyc("R5 evt beats ack", 4'd0, 1, 0, 0, 0);

      // R9 ignored accesses
      cyc("R9 wr ack", 4'd1, 0, 1, 32'hFFFF_FFFF, 0);
      cyc("R9 after ack wr", 4'd0, 1, 0, 0, 0);
      cyc("R9 wr unmapped", 4'd6, 0, 1, 32'hFFFF_FFFF, 0);
      cyc("R9 rd unmapped", 4'd6, 1, 0, 0, 0);
      cyc("R9 rd high", 4'd15, 1, 0, 0, 0);
      cyc("R9 mask kept", 4'd2, 1, 0, 0, 0);
      cyc("R9 glb kept", 4'd3, 1, 0, 0, 0);

      // R7 global disable drops the line
      cyc("R7 glb off", 4'd3, 0, 1, 32'h0, 32'h4);
      idle(3);

      // Mixed traffic compared on every clock
      for (int n = 0; n < 600; n++) begin
         logic [3:0]  a;
         logic [31:0] ev;
         a  = 4'($urandom_range(0, 5));
         ev = (($urandom_range(0, 3) == 0) ? $urandom : 32'h0) & $urandom;
         cyc("R2 mixed read", a, 1'($urandom_range(0, 1)),
             1'($urandom_range(0, 2) == 0), $urandom, ev);
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule